// File: doc/BRIEF.md
# Sampled phase-frequency detector with pump controls and lock status

This block compares two pulse trains, one from a reference divider and one from a feedback divider, and turns their timing difference into digital pump commands for an external charge pump. Both inputs are sampled by a fast clock, and only their rising edges matter. If the reference edge arrives first, the block raises its "pump up" command. If the feedback edge arrives first, it raises "pump down". Once both edges have been seen, both commands stay on together for a fixed short window and then clear, so that small phase errors are never lost in a dead zone.

Several configuration inputs adjust the outputs. A polarity input exchanges the up and down commands, which suits oscillators whose frequency falls as their control voltage rises. A gain input selects 1x or 4x pump current. The same gain input drives a fast-lock switch output whenever 4x is chosen. A drive-enable output is low whenever the pump should float (tri-state).

A lock flag is updated once per comparison, at the later of the two edges. It is high when the pump stayed idle during that comparison, meaning both edges fell in the same sample, and low otherwise. In power-down the pump commands are forced off, the comparison in progress is abandoned, and the lock flag is held high.

The core is a four-state machine:
- `ST_IDLE`: waiting for either edge.
- `ST_UP`: the reference edge has arrived and the feedback edge has not.
- `ST_DN`: the feedback edge has arrived and the reference edge has not.
- `ST_CLR`: both edges have arrived and both commands are on.

The transitions are:
- `ST_IDLE` to `ST_UP` on a reference edge alone.
- `ST_IDLE` to `ST_DN` on a feedback edge alone.
- `ST_IDLE` to `ST_CLR` on both edges in the same sample.
- `ST_UP` to `ST_CLR` on a feedback edge.
- `ST_DN` to `ST_CLR` on a reference edge.
- `ST_CLR` to `ST_IDLE` after `DLY_CYCLES` cycles.
- Any state to `ST_IDLE` while power-down is asserted.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: After reset, `pump_up`, `pump_dn`, `pump_en` and `lock_ok` are all 0 until the first rising edge is sampled.
- R2: A rising edge on `ref_pulse` that arrives with no feedback edge pending makes `pump_up` 1 from the following clock edge. `pump_up` stays 1 until the clear window ends. The mirror case holds for `fb_pulse` and `pump_dn`.
- R3: Once both edges have been sampled, `pump_up` and `pump_dn` are both 1 for exactly `DLY_CYCLES` cycles (default 3). After that both are 0 for at least one cycle.
- R4: While a comparison waits for its second edge, further edges on the leading input are ignored. Every edge that arrives during the clear window, or in the cycle the window ends, is ignored.
- R5: With `invert_pol` = 1, `pump_up` carries the feedback-leading command and `pump_dn` carries the reference-leading command.
- R6: `pump_en` is 1 exactly when `pump_up` or `pump_dn` is 1. When `pump_en` is 0, the pump is in tri-state.
- R7: `pump_4x` and `fast_lock` equal `gain_4x` in the same cycle. A value of 1 means 4x current with the fast-lock switch closed; 0 means 1x current.
- R8: `lock_ok` changes only at the clock edge that samples a comparison's later edge. It becomes 1 if both edges were sampled in the same cycle and 0 if one edge led the other. It holds its value between comparisons.
- R9: While `pwr_down` = 1, the pump commands are 0 in the same cycle. The pending comparison is discarded, and `lock_ok` is 1 from the next clock edge. After release, the detector restarts from `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference divider output, synchronous to `clk` |
| fb_pulse | input | 1 | Feedback divider output, synchronous to `clk` |
| pwr_down | input | 1 | Power-down: pumps off, lock flag high |
| invert_pol | input | 1 | 1 exchanges the up and down commands |
| gain_4x | input | 1 | 1 selects 4x pump current |
| pump_up | output | 1 | Pump-up command |
| pump_dn | output | 1 | Pump-down command |
| pump_en | output | 1 | Pump drive enable (0 means tri-state) |
| pump_4x | output | 1 | Current-gain control to the pump |
| fast_lock | output | 1 | Fast-lock resistor switch |
| lock_ok | output | 1 | Lock status of the last comparison |

## Verification
Timing of the results:
- The pump commands and `lock_ok` change at the first clock edge that samples the rising input level. They are therefore due one cycle after the input changes.
- The clear window then closes `DLY_CYCLES` edges later.
- `pump_4x`, `fast_lock`, and the power-down gating of the pump commands follow their inputs within the same cycle.
- `lock_ok` reaches its power-down value at the next edge.

How the checks keep to that timing:
- The bench drives inputs on the falling clock edge.
- A behavioural model advances on each rising edge from the same sampled inputs.
- Every output is compared one time unit after that rising edge. Each result is therefore checked in exactly the cycle it is due, never earlier or later.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_CLR  = 2'd3
    } pfd_state_t;

    localparam int unsigned PFD_CHANNELS = 2;
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int unsigned CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] lvl,
    output logic [CH-1:0] rise
);
    // One rising-edge detector per input channel.
    for (genvar i = 0; i < CH; i++) begin : g_ch
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
#(
    parameter int unsigned DLY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic ref_edge,
    input  logic fb_edge,
    output logic up_raw,
    output logic dn_raw,
    output logic cmp_done,
    output logic cmp_skewed
);
    localparam int unsigned CW = $clog2(DLY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_CYCLES - 1);

    pfd_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (pwr_down) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    // Clear-window length counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (pwr_down || state_q != ST_CLR) cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_edge && fb_edge) state_d = ST_CLR;
                else if (ref_edge)       state_d = ST_UP;
                else if (fb_edge)        state_d = ST_DN;
            end
            ST_UP:  if (fb_edge)  state_d = ST_CLR;
            ST_DN:  if (ref_edge) state_d = ST_CLR;
            ST_CLR: if (cnt_q == LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        up_raw     = 1'b0;
        dn_raw     = 1'b0;
        cmp_skewed = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_UP:  begin up_raw = 1'b1; cmp_skewed = 1'b1; end
            ST_DN:  begin dn_raw = 1'b1; cmp_skewed = 1'b1; end
            ST_CLR: begin up_raw = 1'b1; dn_raw = 1'b1; end
            default: ;
        endcase
        cmp_done = (state_q != ST_CLR) && (state_d == ST_CLR) && !pwr_down;
    end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic cmp_done,
    input  logic cmp_skewed,
    output logic lock_ok
);
    logic lock_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lock_q <= 1'b0;
        else if (pwr_down) lock_q <= 1'b1;
        else if (cmp_done) lock_q <= ~cmp_skewed;
    end
    assign lock_ok = lock_q;
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
    import pfd_pkg::*;
#(
    parameter int unsigned DLY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic pwr_down,
    input  logic invert_pol,
    input  logic gain_4x,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_en,
    output logic pump_4x,
    output logic fast_lock,
    output logic lock_ok
);
    logic [PFD_CHANNELS-1:0] lvl, rise;
    logic up_raw, dn_raw, cmp_done, cmp_skewed, up_g, dn_g;

    assign lvl[CH_REF] = ref_pulse;
    assign lvl[CH_FB]  = fb_pulse;

    pfd_edge_det #(.CH(PFD_CHANNELS)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
    );

    pfd_fsm #(.DLY_CYCLES(DLY_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .ref_edge(rise[CH_REF]), .fb_edge(rise[CH_FB]),
        .up_raw(up_raw), .dn_raw(dn_raw),
        .cmp_done(cmp_done), .cmp_skewed(cmp_skewed)
    );

    pfd_lock_det u_lock (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .cmp_done(cmp_done), .cmp_skewed(cmp_skewed), .lock_ok(lock_ok)
    );

    assign up_g      = up_raw & ~pwr_down;
    assign dn_g      = dn_raw & ~pwr_down;
    assign pump_up   = invert_pol ? dn_g : up_g;
    assign pump_dn   = invert_pol ? up_g : dn_g;
    assign pump_en   = up_g | dn_g;
    assign pump_4x   = gain_4x;
    assign fast_lock = gain_4x;
endmodule

// File: rtl/pfd_lock_ctrl_chk.sv
module pfd_lock_ctrl_chk #(
    parameter int unsigned DLY_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_en,
    input logic lock_ok
);
    localparam int unsigned CW = $clog2(DLY_CYCLES + 2);
    logic [CW-1:0] both_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     both_cnt <= '0;
        else if (!(pump_up && pump_dn)) both_cnt <= '0;
        else if (both_cnt <= CW'(DLY_CYCLES)) both_cnt <= both_cnt + 1'b1;
    end

    AST_CLR_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        both_cnt <= CW'(DLY_CYCLES)); // R3

    AST_PD_PUMPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!pump_up && !pump_dn && !pump_en)); // R9

    AST_PD_LOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> lock_ok); // R9

    AST_LOCK_CHANGE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_ok) |-> ($past(pwr_down) || (pump_up && pump_dn))); // R8

    AST_EN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_en) |-> ($past(pump_up && pump_dn) || pwr_down || $past(pwr_down))); // R6
endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_chk #(.DLY_CYCLES(DLY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en), .lock_ok(lock_ok)
);

// File: tb/pfd_lock_ctrl_bench.sv
`timescale 1ns/1ps
module pfd_lock_ctrl_bench;
    localparam int DLY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0, pwr_down = 1'b0;
    logic invert_pol = 1'b0, gain_4x = 1'b0;
    logic pump_up, pump_dn, pump_en, pump_4x, fast_lock, lock_ok;

    int compared = 0, mismatched = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural model state.
    bit m_pref, m_pfb, m_ref_wait, m_fb_wait, m_lock;
    int m_hold;

    always #5 clk = ~clk;

    pfd_lock_ctrl #(.DLY_CYCLES(DLY)) u_pfd_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .pwr_down(pwr_down), .invert_pol(invert_pol), .gain_4x(gain_4x),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
        .pump_4x(pump_4x), .fast_lock(fast_lock), .lock_ok(lock_ok)
    );

    task automatic chk(string tag, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s (%s) t=%0t actual=%b expected=%b", tag, cur_req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit re, fe, nr, nf, eu, ed;
        if (!rst_n) begin
            m_pref = 0; m_pfb = 0; m_ref_wait = 0; m_fb_wait = 0; m_lock = 0; m_hold = 0;
        end else begin
            re = ref_pulse && !m_pref;
            fe = fb_pulse && !m_pfb;
            m_pref = ref_pulse;
            m_pfb = fb_pulse;
            if (pwr_down) begin
                m_ref_wait = 0; m_fb_wait = 0; m_hold = 0; m_lock = 1;
            end else if (m_hold > 0) begin
                m_hold--;
            end else begin
                nr = m_ref_wait || re;
                nf = m_fb_wait || fe;
                if (nr && nf) begin
                    m_lock = !(m_ref_wait || m_fb_wait);
                    m_hold = DLY;
                    m_ref_wait = 0; m_fb_wait = 0;
                end else begin
                    m_ref_wait = nr; m_fb_wait = nf;
                end
            end
        end
        #1;
        eu = (m_ref_wait || m_hold > 0) && !pwr_down;
        ed = (m_fb_wait  || m_hold > 0) && !pwr_down;
        if (!done) begin
            chk("R2 R3 R5 pump_up", pump_up, invert_pol ? ed : eu);
            chk("R2 R3 R5 pump_dn", pump_dn, invert_pol ? eu : ed);
            chk("R6 pump_en", pump_en, eu || ed);
            chk("R7 pump_4x", pump_4x, gain_4x);
            chk("R7 fast_lock", fast_lock, gain_4x);
            chk("R8 lock_ok", lock_ok, m_lock);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit r, bit f);
        @(negedge clk);
        ref_pulse = r; fb_pulse = f;
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int unsigned x;
        idle(3);
        rst_n = 1;
        cur_req = "R1"; idle(3);
        // R1: explicit check of quiet state after reset
        chk("R1 pump_en", pump_en, 1'b0);
        chk("R1 lock_ok", lock_ok, 1'b0);

        cur_req = "R2";
        pulse(1, 0); idle(3); pulse(0, 1); idle(6);
        pulse(0, 1); idle(4); pulse(1, 0); idle(6);

        cur_req = "R3";
        pulse(1, 1); idle(6);

        cur_req = "R4";
        pulse(1, 0); idle(1); pulse(1, 0); idle(2); pulse(0, 1);
        pulse(1, 1); idle(1); pulse(0, 1); idle(6);

        cur_req = "R5";
        invert_pol = 1;
        pulse(1, 0); idle(2); pulse(0, 1); idle(6);
        pulse(0, 1); idle(2); pulse(1, 0); idle(6);
        invert_pol = 0;

        cur_req = "R7";
        gain_4x = 1; pulse(1, 0); pulse(0, 1); idle(5);
        gain_4x = 0; idle(2);

        cur_req = "R8";
        pulse(1, 1); idle(6);
        pulse(1, 0); pulse(0, 1); idle(6);
        pulse(1, 1); idle(6);

        cur_req = "R9";
        pulse(1, 0); idle(1);
        pwr_down = 1; idle(3);
        // R9: lock held high in power-down
        chk("R9 lock_ok", lock_ok, 1'b1);
        pwr_down = 0; idle(3);
        pulse(0, 1); idle(2); pulse(1, 0); idle(6);
        pulse(1, 1); idle(1); pwr_down = 1; idle(2); pwr_down = 0; idle(4);

        cur_req = "R6";
        x = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            x = x * 32'd1103515245 + 32'd12345;
            ref_pulse  = x[20] & x[21];
            fb_pulse   = x[22] & x[23];
            invert_pol = x[26] & x[27] & x[28];
            gain_4x    = x[29];
            pwr_down   = (x[30:24] == 7'h11);
        end
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0; pwr_down = 0;
        idle(8);
        finish_run();
    end
endmodule